// File: doc/BRIEF.md
# RTC Alarm Interrupt Router

This block sits beside a real-time clock's alarm comparator and countdown timer. It turns their single-cycle event strobes into interrupt pin drive. It holds an 8-bit command register. Six of its bits are written by software. The other two are sticky alarm flags that only hardware updates. One flag records a time-of-day match and the other records a countdown expiry.

Each flag has a mask bit. A swap bit decides which of the two interrupt pins carries which source. The first pin ("P") can only pull low. The second pin ("B") drives either high or low when active and is released when idle. A mode bit selects how an active pin behaves. In level mode the pin follows its flag. In pulse mode the pin is held for a fixed number of clock cycles. A flag is cleared when software touches its source's own data registers, not by writing the flag bit. The register bus gives every access as a one-cycle valid strobe.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset the command read value is 0x00, pin P does not sink, pin B is not driven and `irq_b_out` is 0.
- R2: A write to address 0xB loads bits 7..2 of the command register from `acc_wdata[7:2]`; bits 1 and 0 ignore the written data.
- R3: `tod_event` sets flag bit 0 and `wdog_event` sets flag bit 1, from the following cycle, whether or not the source is masked.
- R4: Any access, read or write, to address 3, 5 or 7 clears bit 0; any access to address 0xC or 0xD clears bit 1; other addresses leave both flags unchanged.
- R5: When a set strobe and a clearing access for the same flag arrive in one cycle, the flag ends set.
- R6: Bit 2 set masks the time-of-day source and bit 3 set masks the countdown source: a masked source never starts or holds pin drive.
- R7: With bit 6 set, pin P carries the time-of-day source and pin B the countdown source; with bit 6 clear the two are exchanged.
- R8: When pin B is active, `irq_b_oe` is 1 and `irq_b_out` equals bit 5 (1 = drive high, 0 = drive low); when inactive, `irq_b_oe` and `irq_b_out` are 0. Pin P only ever sinks.
- R9: With bit 4 clear (level mode), a pin is active exactly while its routed flag is set and that source is unmasked.
- R10: With bit 4 set (pulse mode), an unmasked routed event makes its pin active for exactly PULSE_CYCLES cycles, starting the cycle after the strobe; a further event during a pulse restarts the full count.
- R11: Bit 7 is readable and is presented on `transfer_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | One-cycle register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address of the access |
| acc_wdata | input | 8 | Write data |
| tod_event | input | 1 | Time-of-day alarm match strobe |
| wdog_event | input | 1 | Countdown timeout strobe |
| cmd_rdata | output | 8 | Current command register value including flags |
| transfer_en | output | 1 | Time register update enable (bit 7) |
| irq_p_sink | output | 1 | Pin P pull-down enable |
| irq_b_oe | output | 1 | Pin B output enable |
| irq_b_out | output | 1 | Pin B driven value |

## Verification
The assertions take for granted that `acc_valid` and the event strobes are clean single-cycle signals sampled on the rising clock edge. They also assume that the register reads back exactly the state the pins are derived from. The pulse-width property relies on the checker seeing the same routing and mask bits that the design used when it started the pulse. The stimulus drives every input only between edges. Random addresses span the full address space, and events and writes are mixed freely, so swap, mask and mode bits change mid-pulse. A bench model recomputes every output from the requirements each cycle.

// File: rtl/alarm_irq_pkg.sv
// Shared constants and the control-field type of the alarm interrupt router.
// Assumes a register address space of at most 16 locations.
package alarm_irq_pkg;
    localparam int ADDR_CMD    = 'hB;
    localparam int ADDR_TOD_A  = 'h3;
    localparam int ADDR_TOD_B  = 'h5;
    localparam int ADDR_TOD_C  = 'h7;
    localparam int ADDR_WD_LO  = 'hC;
    localparam int ADDR_WD_HI  = 'hD;
    localparam int NUM_PINS    = 2;
    localparam int PIN_P       = 0;
    localparam int PIN_B       = 1;

    // Software-owned part of the command register, bit 7 down to bit 2.
    typedef struct packed {
        logic xfer_en;
        logic swap;
        logic b_high;
        logic pulse;
        logic wd_mask;
        logic tod_mask;
    } ctrl_t;
endpackage

// File: rtl/irq_cmd_regs.sv
// Command register and the two sticky alarm flags.
// Assumes acc_valid marks exactly one access per cycle; set events win
// over clearing accesses in the same cycle.
module irq_cmd_regs
    import alarm_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    input  logic              tod_event,
    input  logic              wdog_event,
    output ctrl_t             ctrl,
    output logic              tod_flag,
    output logic              wd_flag
);
    logic hit_cmd;
    logic hit_tod;
    logic hit_wd;

    // Decode which register group the current access touches.
    always_comb begin
        hit_cmd = acc_valid && (acc_addr == ADDR_W'(ADDR_CMD));
        hit_tod = acc_valid && ((acc_addr == ADDR_W'(ADDR_TOD_A)) ||
                                (acc_addr == ADDR_W'(ADDR_TOD_B)) ||
                                (acc_addr == ADDR_W'(ADDR_TOD_C)));
        hit_wd  = acc_valid && ((acc_addr == ADDR_W'(ADDR_WD_LO)) ||
                                (acc_addr == ADDR_W'(ADDR_WD_HI)));
    end

    // Load the software-owned bits on a command write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (hit_cmd && acc_write)
            ctrl <= ctrl_t'(acc_wdata[7:2]);
    end

    // Sticky flags: set by the strobe, cleared by a source-register access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_flag <= 1'b0;
            wd_flag  <= 1'b0;
        end else begin
            tod_flag <= tod_event  | (tod_flag & ~hit_tod);
            wd_flag  <= wdog_event | (wd_flag  & ~hit_wd);
        end
    end
endmodule

// File: rtl/irq_pulse_timer.sv
// Retriggerable one-shot: busy for CYCLES clocks after the last trigger.
// Assumes CYCLES >= 1.
module irq_pulse_timer #(
    parameter int CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Reload on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (trigger)
            remain <= CNT_W'(CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // The pulse lasts while any count remains.
    always_comb busy = (remain != '0);
endmodule

// File: rtl/irq_pin_route.sv
// Maps the two alarm sources onto the two pins under the swap bit and
// applies the masks. Purely combinational.
module irq_pin_route
    import alarm_irq_pkg::*;
(
    input  ctrl_t       ctrl,
    input  logic        tod_flag,
    input  logic        wd_flag,
    input  logic        tod_event,
    input  logic        wdog_event,
    output logic [1:0]  pin_level,
    output logic [1:0]  pin_trig
);
    logic tod_lvl, wd_lvl, tod_trg, wd_trg;

    // Qualify each source by its mask.
    always_comb begin
        tod_lvl = tod_flag   & ~ctrl.tod_mask;
        wd_lvl  = wd_flag    & ~ctrl.wd_mask;
        tod_trg = tod_event  & ~ctrl.tod_mask;
        wd_trg  = wdog_event & ~ctrl.wd_mask;
    end

    // Steer the qualified sources to pin P and pin B.
    always_comb begin
        if (ctrl.swap) begin
            pin_level[PIN_P] = tod_lvl;
            pin_trig[PIN_P]  = tod_trg;
            pin_level[PIN_B] = wd_lvl;
            pin_trig[PIN_B]  = wd_trg;
        end else begin
            pin_level[PIN_P] = wd_lvl;
            pin_trig[PIN_P]  = wd_trg;
            pin_level[PIN_B] = tod_lvl;
            pin_trig[PIN_B]  = tod_trg;
        end
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Top of the alarm interrupt router: command register, flags, routing,
// per-pin pulse timers and open-drain style pin enables.
// Assumes event strobes and accesses are one-cycle, synchronous to clk.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int PULSE_CYCLES = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    input  logic              tod_event,
    input  logic              wdog_event,
    output logic [7:0]        cmd_rdata,
    output logic              transfer_en,
    output logic              irq_p_sink,
    output logic              irq_b_oe,
    output logic              irq_b_out
);
    ctrl_t      ctrl;
    logic       tod_flag;
    logic       wd_flag;
    logic [1:0] pin_level;
    logic [1:0] pin_trig;
    logic [1:0] pin_busy;
    logic [1:0] pin_act;

    irq_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .tod_event  (tod_event),
        .wdog_event (wdog_event),
        .ctrl       (ctrl),
        .tod_flag   (tod_flag),
        .wd_flag    (wd_flag)
    );

    irq_pin_route u_route (
        .ctrl       (ctrl),
        .tod_flag   (tod_flag),
        .wd_flag    (wd_flag),
        .tod_event  (tod_event),
        .wdog_event (wdog_event),
        .pin_level  (pin_level),
        .pin_trig   (pin_trig)
    );

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        irq_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .trigger (pin_trig[gi]),
            .busy    (pin_busy[gi])
        );

        // Pick pulse or level behaviour for this pin.
        always_comb pin_act[gi] = ctrl.pulse ? pin_busy[gi] : pin_level[gi];
    end

    // Present register state and drive the pins.
    always_comb begin
        cmd_rdata   = {ctrl, wd_flag, tod_flag};
        transfer_en = ctrl.xfer_en;
        irq_p_sink  = pin_act[PIN_P];
        irq_b_oe    = pin_act[PIN_B];
        irq_b_out   = pin_act[PIN_B] & ctrl.b_high;
    end
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
// Property checker for alarm_irq_ctrl, attached by bind. Observes ports only.
module alarm_irq_ctrl_chk #(
    parameter int ADDR_W       = 4,
    parameter int PULSE_CYCLES = 300000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        acc_wdata,
    input logic              tod_event,
    input logic              wdog_event,
    input logic [7:0]        cmd_rdata,
    input logic              transfer_en,
    input logic              irq_p_sink,
    input logic              irq_b_oe,
    input logic              irq_b_out
);
    logic acc_tod, acc_wd, acc_cmdw, p_trig;
    logic [31:0] p_age;

    // Decode accesses and the pin P trigger as seen from the ports.
    always_comb begin
        acc_tod  = acc_valid && (acc_addr == ADDR_W'(3) || acc_addr == ADDR_W'(5) ||
                                 acc_addr == ADDR_W'(7));
        acc_wd   = acc_valid && (acc_addr == ADDR_W'(12) || acc_addr == ADDR_W'(13));
        acc_cmdw = acc_valid && acc_write && (acc_addr == ADDR_W'(11));
        p_trig   = cmd_rdata[6] ? (tod_event && !cmd_rdata[2])
                                : (wdog_event && !cmd_rdata[3]);
    end

    // Cycles since the last pin P trigger, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            p_age <= 32'hFFFF_FFFF;
        else if (p_trig)
            p_age <= 32'd1;
        else if (p_age != 32'hFFFF_FFFF)
            p_age <= p_age + 32'd1;
    end

    AST_FLAGS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cmdw && !tod_event && !wdog_event) |=> cmd_rdata[1:0] == $past(cmd_rdata[1:0])); // R2
    AST_WD_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_event |=> cmd_rdata[1]); // R3
    AST_TOD_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_event && acc_tod) |=> cmd_rdata[0]); // R5
    AST_TOD_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_tod && !tod_event) |=> !cmd_rdata[0]); // R4
    AST_WD_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wd && !wdog_event) |=> !cmd_rdata[1]); // R4
    AST_MASKED_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[4] && cmd_rdata[3] && cmd_rdata[2]) |-> (!irq_p_sink && !irq_b_oe)); // R6
    AST_LEVEL_P_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[4] && irq_p_sink) |-> (cmd_rdata[6] ? cmd_rdata[0] : cmd_rdata[1])); // R7
    AST_B_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_b_oe |-> !irq_b_out); // R8
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[4] && irq_p_sink) |-> (p_age <= 32'(PULSE_CYCLES))); // R10
    AST_XFER_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        transfer_en == cmd_rdata[7]); // R11
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.ADDR_W(ADDR_W), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .tod_event(tod_event),
    .wdog_event(wdog_event), .cmd_rdata(cmd_rdata), .transfer_en(transfer_en),
    .irq_p_sink(irq_p_sink), .irq_b_oe(irq_b_oe), .irq_b_out(irq_b_out)
);

// File: tb/alarm_irq_ctrl_test.sv
// Self-checking bench: directed corners then seeded random traffic,
// compared each cycle against a model built from the requirements.
module alarm_irq_ctrl_test;
    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       tod_event = 1'b0, wdog_event = 1'b0;
    logic [7:0] cmd_rdata;
    logic       transfer_en, irq_p_sink, irq_b_oe, irq_b_out;

    int n_chk = 0, n_bad = 0;
    logic [7:2] m_ctl;
    logic m_tdf, m_waf;
    int m_tp, m_tb;

    always #5 clk = ~clk;

    alarm_irq_ctrl #(.ADDR_W(4), .PULSE_CYCLES(N)) uut (.*);

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_p();
        if (m_ctl[4]) return m_tp != 0;
        return m_ctl[6] ? (m_tdf && !m_ctl[2]) : (m_waf && !m_ctl[3]);
    endfunction

    function automatic logic exp_b();
        if (m_ctl[4]) return m_tb != 0;
        return m_ctl[6] ? (m_waf && !m_ctl[3]) : (m_tdf && !m_ctl[2]);
    endfunction

    task automatic compare_all();
        chk("R2 R3 R4 R5 rdata", cmd_rdata, {m_ctl, m_waf, m_tdf});
        chk("R11 transfer_en", {7'd0, transfer_en}, {7'd0, m_ctl[7]});
        chk("R6 R7 R9 R10 pinP", {7'd0, irq_p_sink}, {7'd0, exp_p()});
        chk("R8 pinB", {6'd0, irq_b_oe, irq_b_out},
            {6'd0, exp_b(), exp_b() & m_ctl[5]});
    endtask

    // One bus cycle: drive at the falling edge, update the model at the
    // rising edge, compare at the next falling edge.
    task automatic step(logic v, logic w, logic [3:0] a, logic [7:0] d, logic te, logic we);
        logic tclr, wclr, ptr, btr, ttr, wtr;
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
        tod_event = te; wdog_event = we;
        @(posedge clk);
        tclr = v && (a == 4'h3 || a == 4'h5 || a == 4'h7);
        wclr = v && (a == 4'hC || a == 4'hD);
        ttr  = te && !m_ctl[2];
        wtr  = we && !m_ctl[3];
        ptr  = m_ctl[6] ? ttr : wtr;
        btr  = m_ctl[6] ? wtr : ttr;
        m_tp = ptr ? N : (m_tp > 0 ? m_tp - 1 : 0);
        m_tb = btr ? N : (m_tb > 0 ? m_tb - 1 : 0);
        m_tdf = te | (m_tdf & !tclr);
        m_waf = we | (m_waf & !wclr);
        if (v && w && a == 4'hB) m_ctl = d[7:2];
        @(negedge clk);
        acc_valid = 1'b0; tod_event = 1'b0; wdog_event = 1'b0;
        compare_all();
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pcount;
        void'($urandom(32'd1234));
        m_ctl = '0; m_tdf = 0; m_waf = 0; m_tp = 0; m_tb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset rdata", cmd_rdata, 8'h00);
        chk("R1 reset pins", {5'd0, irq_p_sink, irq_b_oe, irq_b_out}, 8'h00);

        // R2: flag bits ignore written data
        step(1, 1, 4'hB, 8'hFF, 0, 0);
        chk("R2 write FF", cmd_rdata, 8'hFC);
        step(1, 1, 4'hB, 8'h00, 0, 0);

        // R7: swap clear sends time-of-day to pin B, active low
        step(0, 0, 4'h0, 8'h00, 1, 0);
        chk("R7 tod on B", {5'd0, irq_p_sink, irq_b_oe, irq_b_out}, 8'h02);

        // R5: set and clear together, set wins; R4: clear alone
        step(1, 0, 4'h5, 8'h00, 1, 0);
        chk("R5 set wins", cmd_rdata & 8'h01, 8'h01);
        step(1, 0, 4'h9, 8'h00, 0, 0);
        chk("R4 other addr keeps", cmd_rdata & 8'h01, 8'h01);
        step(1, 1, 4'h7, 8'h00, 0, 0);
        chk("R4 tod clear", cmd_rdata & 8'h01, 8'h00);

        // R3 R6: masked countdown still flags, pins quiet
        step(1, 1, 4'hB, 8'h0C, 0, 0);
        step(0, 0, 4'h0, 8'h00, 0, 1);
        chk("R3 masked flag", cmd_rdata, 8'h0E);
        chk("R6 masked pins", {6'd0, irq_p_sink, irq_b_oe}, 8'h00);
        step(1, 0, 4'hD, 8'h00, 0, 0);

        // R8: pin B active high
        step(1, 1, 4'hB, 8'h60, 0, 1);
        chk("R8 B drive high", {6'd0, irq_b_oe, irq_b_out}, 8'h03);
        step(1, 0, 4'hC, 8'h00, 0, 0);

        // R10: pulse on P with a restart
        step(1, 1, 4'hB, 8'h50, 0, 0);
        step(0, 0, 4'h0, 8'h00, 1, 0);
        repeat (2) step(0, 0, 4'h0, 8'h00, 0, 0);
        step(0, 0, 4'h0, 8'h00, 1, 0);
        pcount = irq_p_sink ? 1 : 0;
        for (int i = 0; i < 2 * N; i++) begin
            step(0, 0, 4'h0, 8'h00, 0, 0);
            if (irq_p_sink) pcount++;
        end
        chk("R10 restarted width", 8'(pcount), 8'(N));

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(r[0], r[1], 4'($urandom), 8'($urandom),
                 ($urandom % 6) == 0, ($urandom % 6) == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule